// File: doc/BRIEF.md
# Accelerator Instruction Claim Decoder

This block sits on the accelerator side of a core-to-accelerator request channel. The core presents an instruction word with a valid flag. The decoder answers in the same cycle, with purely combinational logic, and the answer is qualified by a ready output that is held high. It first works out the instruction length from the low opcode bits, in the standard RISC-V way. It then decides whether this accelerator takes the instruction and which of three source operands (A, B, C) the core must supply. It also names the destination register and says whether the result occupies a register pair.

Claiming is driven by a parameterised table of mask/value pairs compared against the instruction word. By default the table holds the two custom major opcodes. When an instruction arrives in its 16-bit form, only the low half of the word is kept; the upper half may carry unrelated bits and is cleared before any decode. A paired writeback to Xn and Xn+1 is requested only for the selected operation, and only when n is even and not x0. Execution, result return and the register file belong elsewhere.

Top module: `accel_claim_decoder`

## Requirements
- R1: `req_ready` is 1 at all times.
- R2: While `req_valid` is 0, `rsp_claim`, `rsp_use_a`, `rsp_use_b`, `rsp_use_c`, `rsp_pair` and `rsp_dest` are all 0.
- R3: A word with bits [1:0] not equal to 2'b11 is a 16-bit instruction. A word with bits [1:0] = 2'b11 and bits [4:2] = 3'b111 is a longer-than-32-bit instruction. Neither kind is ever claimed.
- R4: For a 16-bit instruction, bits [31:16] have no effect on any output.
- R5: `rsp_claim` is 1 exactly when `req_valid` is 1, the word is 32-bit, and bits [6:0] equal 7'b0001011 or 7'b0101011.
- R6: `rsp_use_a` and `rsp_use_b` equal `rsp_claim`. `rsp_use_c` is 1 only on a claimed word whose bits [14:12] equal 3'b110.
- R7: `rsp_dest` equals bits [11:7] of a claimed word, and is 0 otherwise.
- R8: `rsp_pair` is 1 exactly on a claimed word whose bits [14:12] equal 3'b111 and whose bits [11:7] are even and nonzero.
- R9: With bits [14:12] = 3'b111, a destination that is odd or is x0 gives `rsp_pair` = 0 while the claim still stands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_valid | input | 1 | Initiator presents an instruction |
| req_instr | input | 32 | Instruction word, short forms in the low bits |
| req_ready | output | 1 | Responses are valid (held high) |
| rsp_claim | output | 1 | This accelerator takes the instruction |
| rsp_use_a | output | 1 | Operand A is needed |
| rsp_use_b | output | 1 | Operand B is needed |
| rsp_use_c | output | 1 | Operand C is needed |
| rsp_dest | output | 5 | Destination register index |
| rsp_pair | output | 1 | Result written to rsp_dest and rsp_dest+1 |

## Verification
The in-line checks assume that `req_valid` and `req_instr` carry known values whenever they are evaluated, so each check is skipped while either input holds X or Z. The bench keeps to this by giving both inputs defined values from time zero and by changing them only on the falling clock edge, so every checked response is a settled function of a fully known word. Apart from this, the checks take nothing for granted about the instruction stream. Arbitrary upper halves, destination fields and function codes are all legal stimulus.

// File: rtl/accel_dec_pkg.sv
`timescale 1ns/1ps
package accel_dec_pkg;

  typedef enum logic [1:0] {
    LEN_16   = 2'd0,
    LEN_32   = 2'd1,
    LEN_LONG = 2'd2
  } instr_len_e;

  localparam int unsigned WORD_W   = 32;
  localparam int unsigned REG_IDX_W = 5;
  localparam int unsigned FN3_W    = 3;
  localparam int unsigned HALF_W   = WORD_W / 2;

  // Bit positions fixed by the instruction encoding.
  localparam int unsigned DEST_LSB = 7;
  localparam int unsigned FN3_LSB  = 12;

endpackage

// File: rtl/acd_len_decode.sv
`timescale 1ns/1ps
module acd_len_decode
  import accel_dec_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic [W-1:0]  raw_word,
  output instr_len_e    len,
  output logic [W-1:0]  norm_word
);
  localparam int unsigned HW = W / 2;

  logic is_short;
  logic is_long;

  always_comb begin
    is_short = (raw_word[1:0] != 2'b11);
    is_long  = !is_short && (raw_word[4:2] == 3'b111);
    if (is_short)     len = LEN_16;
    else if (is_long) len = LEN_LONG;
    else              len = LEN_32;
  end

  // Short forms live in the low half; the upper half is cleared.
  always_comb begin
    norm_word = raw_word;
    if (is_short) norm_word[W-1:HW] = '0;
  end

  always_comb begin
    if (!$isunknown(raw_word)) begin
      assert_short_len_R3: assert ((len == LEN_16) == (raw_word[1:0] != 2'b11))
        else $error("length class disagrees with low bits");
      assert_short_upper_R4: assert ((len != LEN_16) || (norm_word[W-1:HW] == '0))
        else $error("upper half leaks through for a short form");
    end
  end
endmodule

// File: rtl/acd_claim_table.sv
`timescale 1ns/1ps
module acd_claim_table
  import accel_dec_pkg::*;
#(
  parameter int unsigned W       = WORD_W,
  parameter int unsigned N_ENTRY = 2,
  parameter logic [N_ENTRY*W-1:0] ENTRY_MASK = {32'h0000_007F, 32'h0000_007F},
  parameter logic [N_ENTRY*W-1:0] ENTRY_VAL  = {32'h0000_002B, 32'h0000_000B}
) (
  input  logic          valid,
  input  instr_len_e    len,
  input  logic [W-1:0]  word,
  output logic          claim
);
  logic [N_ENTRY-1:0] hit;

  for (genvar e = 0; e < N_ENTRY; e++) begin : g_entry
    localparam logic [W-1:0] M = ENTRY_MASK[e*W +: W];
    localparam logic [W-1:0] V = ENTRY_VAL[e*W +: W];
    assign hit[e] = ((word & M) == (V & M));
  end

  assign claim = valid && (len == LEN_32) && (|hit);

  always_comb begin
    if (!$isunknown({valid, word})) begin
      assert_claim_len_R5: assert (!claim || (len == LEN_32))
        else $error("claim raised on a non-32-bit form");
      assert_claim_valid_R2: assert (valid || !claim)
        else $error("claim raised without valid");
    end
  end
endmodule

// File: rtl/acd_operand_map.sv
`timescale 1ns/1ps
module acd_operand_map
  import accel_dec_pkg::*;
#(
  parameter logic [FN3_W-1:0] FN3_THIRD = 3'b110
) (
  input  logic             claim,
  input  logic [FN3_W-1:0] fn3,
  output logic             use_a,
  output logic             use_b,
  output logic             use_c
);
  always_comb begin
    use_a = claim;
    use_b = claim;
    use_c = claim && (fn3 == FN3_THIRD);
  end

  always_comb begin
    if (!$isunknown({claim, fn3})) begin
      assert_third_implies_pair_R6: assert (!use_c || (use_a && use_b))
        else $error("operand C requested without A and B");
    end
  end
endmodule

// File: rtl/acd_dest_select.sv
`timescale 1ns/1ps
module acd_dest_select
  import accel_dec_pkg::*;
#(
  parameter int unsigned      RW       = REG_IDX_W,
  parameter logic [FN3_W-1:0] FN3_PAIR = 3'b111
) (
  input  logic             claim,
  input  logic [RW-1:0]    dest_field,
  input  logic [FN3_W-1:0] fn3,
  output logic [RW-1:0]    dest,
  output logic             pair
);
  logic dest_even_nz;

  always_comb begin
    dest_even_nz = (dest_field != '0) && !dest_field[0];
    dest = claim ? dest_field : '0;
    pair = claim && (fn3 == FN3_PAIR) && dest_even_nz;
  end

  always_comb begin
    if (!$isunknown({claim, dest_field, fn3})) begin
      assert_pair_even_R8: assert (!pair || ((dest != '0) && !dest[0]))
        else $error("pair writeback on odd or zero destination");
      assert_dest_idle_R7: assert (claim || (dest == '0))
        else $error("destination driven without claim");
    end
  end
endmodule

// File: rtl/accel_claim_decoder.sv
`timescale 1ns/1ps
module accel_claim_decoder
  import accel_dec_pkg::*;
(
  input  logic                 req_valid,
  input  logic [WORD_W-1:0]    req_instr,
  output logic                 req_ready,
  output logic                 rsp_claim,
  output logic                 rsp_use_a,
  output logic                 rsp_use_b,
  output logic                 rsp_use_c,
  output logic [REG_IDX_W-1:0] rsp_dest,
  output logic                 rsp_pair
);
  instr_len_e          len;
  logic [WORD_W-1:0]   norm_word;

  assign req_ready = 1'b1;

  acd_len_decode #(.W(WORD_W)) u_len (
    .raw_word  (req_instr),
    .len       (len),
    .norm_word (norm_word)
  );

  acd_claim_table #(.W(WORD_W)) u_claim (
    .valid (req_valid),
    .len   (len),
    .word  (norm_word),
    .claim (rsp_claim)
  );

  acd_operand_map u_ops (
    .claim (rsp_claim),
    .fn3   (norm_word[FN3_LSB +: FN3_W]),
    .use_a (rsp_use_a),
    .use_b (rsp_use_b),
    .use_c (rsp_use_c)
  );

  acd_dest_select #(.RW(REG_IDX_W)) u_dest (
    .claim      (rsp_claim),
    .dest_field (norm_word[DEST_LSB +: REG_IDX_W]),
    .fn3        (norm_word[FN3_LSB +: FN3_W]),
    .dest       (rsp_dest),
    .pair       (rsp_pair)
  );

  always_comb begin
    if (!$isunknown({req_valid, req_instr})) begin
      assert_ready_high_R1: assert (req_ready)
        else $error("ready dropped");
      assert_idle_quiet_R2: assert (req_valid ||
          ({rsp_claim, rsp_use_a, rsp_use_b, rsp_use_c, rsp_pair} == '0 && rsp_dest == '0))
        else $error("response active without valid");
      assert_pair_claimed_R9: assert (!rsp_pair || rsp_claim)
        else $error("pair writeback without claim");
    end
  end
endmodule

// File: tb/tb_accel_claim_decoder.sv
`timescale 1ns/1ps
module tb_accel_claim_decoder;

  logic        clk = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_instr = 32'h0;
  logic        req_ready, rsp_claim, rsp_use_a, rsp_use_b, rsp_use_c, rsp_pair;
  logic [4:0]  rsp_dest;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  accel_claim_decoder dut (
    .req_valid(req_valid), .req_instr(req_instr), .req_ready(req_ready),
    .rsp_claim(rsp_claim), .rsp_use_a(rsp_use_a), .rsp_use_b(rsp_use_b),
    .rsp_use_c(rsp_use_c), .rsp_dest(rsp_dest), .rsp_pair(rsp_pair)
  );

  // {valid, instr, claim, a, b, c, dest, pair}
  localparam int NV = 12;
  localparam logic [42:0] VEC [NV] = '{
    {1'b1, 32'h0000_028B, 4'b1110, 5'd5,  1'b0},  // custom-0 fn3=0
    {1'b1, 32'h0000_652B, 4'b1111, 5'd10, 1'b0},  // custom-1 fn3=6 -> C
    {1'b1, 32'h00A5_720B, 4'b1110, 5'd4,  1'b1},  // pair, even rd
    {1'b1, 32'h0000_73AB, 4'b1110, 5'd7,  1'b0},  // pair op, odd rd
    {1'b1, 32'h0000_700B, 4'b1110, 5'd0,  1'b0},  // pair op, x0
    {1'b1, 32'h0000_7F2B, 4'b1110, 5'd30, 1'b1},  // pair, rd 30
    {1'b1, 32'h0000_02B3, 4'b0000, 5'd0,  1'b0},  // other opcode
    {1'b1, 32'h0000_725B, 4'b0000, 5'd0,  1'b0},  // custom-2 not claimed
    {1'b1, 32'hFFFF_720A, 4'b0000, 5'd0,  1'b0},  // 16-bit form
    {1'b1, 32'h0000_001F, 4'b0000, 5'd0,  1'b0},  // 48-bit form
    {1'b1, 32'h0000_703F, 4'b0000, 5'd0,  1'b0},  // longer form, bits[6:2]=01111
    {1'b0, 32'h0000_720B, 4'b0000, 5'd0,  1'b0}   // valid low
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [31:0] w);
    @(negedge clk);
    req_valid = v;
    req_instr = w;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // Idle state (R1, R2)
    drive(1'b0, 32'h0);
    check("R1 ready idle", {31'b0, req_ready}, 32'd1);
    check("R2 idle outputs", {21'b0, rsp_claim, rsp_use_a, rsp_use_b, rsp_use_c, rsp_dest, rsp_pair}, 32'd0);

    // Vector table (R3 R5 R6 R7 R8 R9)
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][42], VEC[i][41:10]);
      check("R5 claim", {31'b0, rsp_claim}, {31'b0, VEC[i][9]});
      check("R6 operands", {29'b0, rsp_use_a, rsp_use_b, rsp_use_c}, {29'b0, VEC[i][8:6]});
      check("R7 dest", {27'b0, rsp_dest}, {27'b0, VEC[i][5:1]});
      check("R8 pair", {31'b0, rsp_pair}, {31'b0, VEC[i][0]});
      check("R1 ready", {31'b0, req_ready}, 32'd1);
    end

    // R4: upper half of a 16-bit form has no effect
    for (int k = 0; k < 16; k++) begin
      logic [31:0] up;
      up = {k[3:0], 12'hA5C} * 32'h0001_0001;
      drive(1'b1, {up[31:16], 16'h720A});
      check("R4 short upper claim", {31'b0, rsp_claim}, 32'd0);
      check("R4 short upper rest", {26'b0, rsp_use_a, rsp_use_b, rsp_use_c, rsp_pair, rsp_dest[1:0]}, 32'd0);
      check("R3 short dest", {27'b0, rsp_dest}, 32'd0);
    end

    // R3: every low-2 code other than 11, and every long form
    for (int c = 0; c < 3; c++) begin
      drive(1'b1, {30'h0000_1C02, c[1:0]});
      check("R3 short never claimed", {31'b0, rsp_claim}, 32'd0);
    end
    for (int h = 0; h < 4; h++) begin
      drive(1'b1, {25'h0000_0E0, h[1:0], 5'b11111});
      check("R3 long never claimed", {31'b0, rsp_claim}, 32'd0);
    end

    // R8, R9: sweep destinations with the pair function code
    for (int r = 0; r < 32; r++) begin
      logic exp_pair;
      exp_pair = (r != 0) && (r % 2 == 0);
      drive(1'b1, 32'h0000_702B | (r << 7));
      check("R9 claim holds", {31'b0, rsp_claim}, 32'd1);
      check("R8 pair sweep", {31'b0, rsp_pair}, {31'b0, exp_pair});
      check("R7 dest sweep", {27'b0, rsp_dest}, r);
    end

    // R6: sweep function codes, operand C only for 3'b110
    for (int f = 0; f < 8; f++) begin
      drive(1'b1, 32'h0000_010B | (f << 12));
      check("R6 use_c sweep", {31'b0, rsp_use_c}, {31'b0, f == 6});
      check("R6 use_a/b sweep", {30'b0, rsp_use_a, rsp_use_b}, 32'd3);
    end

    // R2: valid dropped on a word that would pair
    drive(1'b0, 32'h0000_720B);
    check("R2 valid low quiet", {21'b0, rsp_claim, rsp_use_a, rsp_use_b, rsp_use_c, rsp_dest, rsp_pair}, 32'd0);
    check("R1 ready valid low", {31'b0, req_ready}, 32'd1);

    finish_run();
  end
endmodule